// File: doc/BRIEF.md
# Multiplexed 4:2:2 Component Stream Demultiplexer

This block takes a 10-bit component video stream that runs at twice the pixel rate. Each four-word group carries a Cb word, a Y word, a Cr word and a second Y word. The block splits the stream into parallel Y, Cb and Cr samples at the pixel rate. Each group yields two pixels that share one pair of colour-difference samples. The first pixel uses the Y that follows the Cb. The block does not interpolate the chroma.

The word phase can come from one of three sources, chosen by a select input. The first source is the timing reference codes embedded in the stream. The second is the falling edge of an external horizontal sync. The third is the falling edge of a horizontal sync generated elsewhere on the chip. The block recognises every timing reference, whatever the select input says, and holds the field, vertical-blanking and horizontal flags carried in its status word. Two formatting options act on the stream. One removes a luma blanking offset. The other inverts the most significant bit of each colour-difference sample.

Top module: `demux422_top`

## Requirements
- R1: Within a group, the Cb word, the Y word after it and the Cr word form the first output pixel. The second output pixel uses the group's second Y word with the same Cb and Cr values.
- R2: `pix_vld` goes high for exactly two consecutive cycles per complete group. The first is the cycle after the group's second Y word is sampled. Partial groups produce nothing.
- R3: A timing reference is the three words 0x3FF, 0x000, 0x000 followed by a status word. In embedded mode, a status word with bit 6 (H) equal to 0 is the start-of-video code, and the next word is taken as Cb.
- R4: In every mode, the cycle after a status word is sampled, `f_flag`, `v_flag` and `h_flag` show bits 8, 7 and 6 of that status word. They hold their value until the next status word.
- R5: In embedded mode, an end-of-video status word (bit 6 = 1) never realigns the phase. No pixel is output from that point until a start-of-video code arrives.
- R6: In embedded mode, a 0x3FF word discards the group in progress, including when it arrives in the middle of a group, and stops output until the next start-of-video code. A second pixel that is already pending is still output.
- R7: In external-sync mode (`sync_src` = 1), the word sampled on the first clock edge that sees `hs_ext_n` low is taken as Cb. Any earlier partial group is discarded.
- R8: In internal-sync mode (`sync_src` = 2), the word sampled on the first clock edge that sees `hs_int_n` low is taken as the group's final Y and is not output. The next word is Cb.
- R9: With `luma_ofs_en` high, 64 is subtracted from each luma sample, and results below 0 become 0. With it low, luma passes through unchanged.
- R10: With `chroma_inv_en` high, bit 9 of each Cb and Cr sample is inverted. With it low, chroma passes through unchanged.
- R11: While reset is asserted, all outputs are zero and the phase is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock (twice the pixel rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 10 | Multiplexed Cb/Y/Cr/Y word stream |
| sync_src | input | 2 | Phase source: 0 embedded codes, 1 external sync, 2 internal sync |
| hs_ext_n | input | 1 | External horizontal sync, active low |
| hs_int_n | input | 1 | Internally generated horizontal sync, active low |
| luma_ofs_en | input | 1 | Remove the luma blanking offset of 64 |
| chroma_inv_en | input | 1 | Invert the MSB of Cb and Cr |
| y_out | output | 10 | Luma sample |
| cb_out | output | 10 | Cb sample |
| cr_out | output | 10 | Cr sample |
| pix_vld | output | 1 | Output pixel strobe |
| f_flag | output | 1 | Field bit from the last status word |
| v_flag | output | 1 | Vertical blanking bit from the last status word |
| h_flag | output | 1 | Horizontal bit from the last status word |

## Verification
The pending second pixel of a group and the start of a new timing reference can land in the same cycle. The second pixel must still be output while the group that the preamble interrupts is discarded. The embedded-mode table forces this case by placing 0x3FF in the word slot directly after a group's final Y. It then checks that the Y of that second pixel, with the offset removed, appears with the held chroma, and that no output follows until the next start-of-video code. A preamble in the middle of a group, and an external sync edge arriving one word after a completed group, test the same discard logic from the other side.

// File: rtl/demux422_pkg.sv
package demux422_pkg;
  typedef enum logic [1:0] {
    SRC_EMBED = 2'd0,
    SRC_EXT   = 2'd1,
    SRC_INT   = 2'd2
  } sync_src_e;

  localparam logic [1:0] PH_CB  = 2'd0;
  localparam logic [1:0] PH_Y0  = 2'd1;
  localparam logic [1:0] PH_CR  = 2'd2;
  localparam logic [1:0] PH_Y1  = 2'd3;
endpackage

// File: rtl/demux422_trs_scan.sv
module demux422_trs_scan #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] word_i,
  output logic          sav_o,
  output logic          pre_o,
  output logic          f_o,
  output logic          v_o,
  output logic          h_o
);
  localparam int HIST = 3;
  localparam int FB   = DW - 2;
  localparam int VB   = DW - 3;
  localparam int HB   = DW - 4;
  localparam logic [DW-1:0] ONES  = '1;
  localparam logic [DW-1:0] ZEROS = '0;

  logic [DW-1:0] hist_q [HIST];
  logic [DW-1:0] hist_d [HIST];
  logic          hit;
  logic          f_d, v_d, h_d;
  logic          f_q, v_q, h_q;

  always_comb begin
    hist_d[0] = word_i;
    for (int i = 1; i < HIST; i++) hist_d[i] = hist_q[i-1];
  end

  assign hit   = (hist_q[2] == ONES) && (hist_q[1] == ZEROS) && (hist_q[0] == ZEROS);
  assign sav_o = hit && !word_i[HB];
  assign pre_o = (word_i == ONES);

  always_comb begin
    f_d = f_q;
    v_d = v_q;
    h_d = h_q;
    if (hit) begin
      f_d = word_i[FB];
      v_d = word_i[VB];
      h_d = word_i[HB];
    end
  end

  generate
    for (genvar g = 0; g < HIST; g++) begin : g_hist
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q[g] <= '0;
        else        hist_q[g] <= hist_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q <= 1'b0;
      v_q <= 1'b0;
      h_q <= 1'b0;
    end else begin
      f_q <= f_d;
      v_q <= v_d;
      h_q <= h_d;
    end
  end

  assign f_o = f_q;
  assign v_o = v_q;
  assign h_o = h_q;

  assert_flag_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (h_o == $past(word_i[HB])) && (f_o == $past(word_i[FB])) && (v_o == $past(word_i[VB])));
endmodule

// File: rtl/demux422_phase_ctrl.sv
module demux422_phase_ctrl
  import demux422_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sync_src,
  input  logic       pre_i,
  input  logic       sav_i,
  input  logic       hs_ext_n,
  input  logic       hs_int_n,
  output logic [1:0] cur_ph_o,
  output logic       cap_en_o,
  output logic       grp_clr_o
);
  logic       hs_ext_q, hs_int_q;
  logic       locked_q, locked_d;
  logic [1:0] ph_q, ph_d;
  logic       ext_fall, int_fall, emb_sav, emb_kill, align;
  logic [1:0] cur_ph;

  assign ext_fall = (sync_src == SRC_EXT)   && hs_ext_q && !hs_ext_n;
  assign int_fall = (sync_src == SRC_INT)   && hs_int_q && !hs_int_n;
  assign emb_sav  = (sync_src == SRC_EMBED) && sav_i;
  assign emb_kill = (sync_src == SRC_EMBED) && pre_i;
  assign align    = ext_fall || int_fall || emb_sav;

  always_comb begin
    if (ext_fall)                 cur_ph = PH_CB;
    else if (int_fall || emb_sav) cur_ph = PH_Y1;
    else                          cur_ph = ph_q;
  end

  always_comb begin
    ph_d     = cur_ph + 2'd1;
    locked_d = locked_q;
    if (emb_kill)   locked_d = 1'b0;
    else if (align) locked_d = 1'b1;
  end

  assign cur_ph_o  = cur_ph;
  assign grp_clr_o = align || emb_kill;
  assign cap_en_o  = ext_fall || (locked_q && !emb_kill && !int_fall && !emb_sav);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_ext_q <= 1'b1;
      hs_int_q <= 1'b1;
      locked_q <= 1'b0;
      ph_q     <= PH_CB;
    end else begin
      hs_ext_q <= hs_ext_n;
      hs_int_q <= hs_int_n;
      locked_q <= locked_d;
      ph_q     <= ph_d;
    end
  end

  assert_sav_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    emb_sav |=> (ph_q == PH_CB) && locked_q);
  assert_preamble_unlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    emb_kill |=> !locked_q);
  assert_ext_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fall |=> (ph_q == PH_Y0) && locked_q);
  assert_int_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_fall |=> (ph_q == PH_CB) && locked_q);
endmodule

// File: rtl/demux422_fmt.sv
module demux422_fmt #(
  parameter int DW        = 10,
  parameter int BLANK_OFS = 64
) (
  input  logic [DW-1:0] word_i,
  input  logic          ofs_en,
  input  logic          inv_en,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] c_o
);
  localparam logic [DW-1:0] OFS_W = DW'(BLANK_OFS);

  always_comb begin
    if (!ofs_en)              y_o = word_i;
    else if (word_i < OFS_W)  y_o = '0;
    else                      y_o = word_i - OFS_W;
    c_o = inv_en ? {~word_i[DW-1], word_i[DW-2:0]} : word_i;
  end

  always_comb begin
    assert_luma_not_raised_R9: assert (!ofs_en || (y_o <= word_i));
    assert_chroma_low_bits_R10: assert (c_o[DW-2:0] == word_i[DW-2:0]);
  end
endmodule

// File: rtl/demux422_top.sv
module demux422_top
  import demux422_pkg::*;
#(
  parameter int DW        = 10,
  parameter int BLANK_OFS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic [1:0]    sync_src,
  input  logic          hs_ext_n,
  input  logic          hs_int_n,
  input  logic          luma_ofs_en,
  input  logic          chroma_inv_en,
  output logic [DW-1:0] y_out,
  output logic [DW-1:0] cb_out,
  output logic [DW-1:0] cr_out,
  output logic          pix_vld,
  output logic          f_flag,
  output logic          v_flag,
  output logic          h_flag
);
  logic          rst_meta_n, rst_sync_n;
  logic          sav, pre;
  logic [1:0]    cur_ph;
  logic          cap_en, grp_clr;
  logic [DW-1:0] y_fmt, c_fmt;

  logic [DW-1:0] cb_q, cb_d, y0_q, y0_d, cr_q, cr_d, y1_q, y1_d;
  logic          have_cb_q, have_cb_d, pend_q, pend_d;
  logic [DW-1:0] yo_q, yo_d, cbo_q, cbo_d, cro_q, cro_d;
  logic          vld_q, vld_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  demux422_trs_scan #(.DW(DW)) trs_i (
    .clk(clk), .rst_n(rst_sync_n), .word_i(din),
    .sav_o(sav), .pre_o(pre), .f_o(f_flag), .v_o(v_flag), .h_o(h_flag)
  );

  demux422_phase_ctrl phase_i (
    .clk(clk), .rst_n(rst_sync_n), .sync_src(sync_src),
    .pre_i(pre), .sav_i(sav), .hs_ext_n(hs_ext_n), .hs_int_n(hs_int_n),
    .cur_ph_o(cur_ph), .cap_en_o(cap_en), .grp_clr_o(grp_clr)
  );

  demux422_fmt #(.DW(DW), .BLANK_OFS(BLANK_OFS)) fmt_i (
    .word_i(din), .ofs_en(luma_ofs_en), .inv_en(chroma_inv_en),
    .y_o(y_fmt), .c_o(c_fmt)
  );

  always_comb begin
    cb_d      = cb_q;
    y0_d      = y0_q;
    cr_d      = cr_q;
    y1_d      = y1_q;
    have_cb_d = grp_clr ? 1'b0 : have_cb_q;
    pend_d    = 1'b0;
    yo_d      = yo_q;
    cbo_d     = cbo_q;
    cro_d     = cro_q;
    vld_d     = 1'b0;
    if (pend_q) begin
      yo_d  = y1_q;
      vld_d = 1'b1;
    end
    if (cap_en) begin
      case (cur_ph)
        PH_CB: begin
          cb_d      = c_fmt;
          have_cb_d = 1'b1;
        end
        PH_Y0: y0_d = y_fmt;
        PH_CR: cr_d = c_fmt;
        default: begin
          if (have_cb_q) begin
            yo_d   = y0_q;
            cbo_d  = cb_q;
            cro_d  = cr_q;
            y1_d   = y_fmt;
            pend_d = 1'b1;
            vld_d  = 1'b1;
          end
          have_cb_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cb_q      <= '0;
      y0_q      <= '0;
      cr_q      <= '0;
      y1_q      <= '0;
      have_cb_q <= 1'b0;
      pend_q    <= 1'b0;
      yo_q      <= '0;
      cbo_q     <= '0;
      cro_q     <= '0;
      vld_q     <= 1'b0;
    end else begin
      cb_q      <= cb_d;
      y0_q      <= y0_d;
      cr_q      <= cr_d;
      y1_q      <= y1_d;
      have_cb_q <= have_cb_d;
      pend_q    <= pend_d;
      yo_q      <= yo_d;
      cbo_q     <= cbo_d;
      cro_q     <= cro_d;
      vld_q     <= vld_d;
    end
  end

  assign y_out   = yo_q;
  assign cb_out  = cbo_q;
  assign cr_out  = cro_q;
  assign pix_vld = vld_q;

  assert_pair_length_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pix_vld && $past(pix_vld)) |=> !pix_vld);
  assert_shared_chroma_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pix_vld && $past(pix_vld)) |-> ($stable(cb_out) && $stable(cr_out)));
  assert_pair_second_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pix_vld && !$past(pix_vld)) |=> pix_vld);
endmodule

// File: tb/demux422_tb.sv
module demux422_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] din;
  logic [1:0] sync_src;
  logic       hs_ext_n, hs_int_n, luma_ofs_en, chroma_inv_en;
  logic [9:0] y_out, cb_out, cr_out;
  logic       pix_vld, f_flag, v_flag, h_flag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  demux422_top dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .sync_src(sync_src),
    .hs_ext_n(hs_ext_n), .hs_int_n(hs_int_n),
    .luma_ofs_en(luma_ofs_en), .chroma_inv_en(chroma_inv_en),
    .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out), .pix_vld(pix_vld),
    .f_flag(f_flag), .v_flag(v_flag), .h_flag(h_flag)
  );

  // entry: din[43:34] vld[33] y[32:23] cb[22:13] cr[12:3] {f,v,h}[2:0]
  localparam int NT = 35;
  localparam logic [43:0] TBL [NT] = '{
    {10'h3FF, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h000, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h000, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h200, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h040, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h100, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h3C0, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h150, 1'b1, 10'h0C0, 10'h240, 10'h1C0, 3'b000},
    {10'h080, 1'b1, 10'h110, 10'h240, 10'h1C0, 3'b000},
    {10'h030, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h200, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h3AC, 1'b1, 10'h000, 10'h280, 10'h000, 3'b000},
    {10'h3FF, 1'b1, 10'h36C, 10'h280, 10'h000, 3'b000},
    {10'h000, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h000, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h2D0, 1'b0, 10'h000, 10'h000, 10'h000, 3'b011},
    {10'h100, 1'b0, 10'h000, 10'h000, 10'h000, 3'b011},
    {10'h120, 1'b0, 10'h000, 10'h000, 10'h000, 3'b011},
    {10'h130, 1'b0, 10'h000, 10'h000, 10'h000, 3'b011},
    {10'h140, 1'b0, 10'h000, 10'h000, 10'h000, 3'b011},
    {10'h3FF, 1'b0, 10'h000, 10'h000, 10'h000, 3'b011},
    {10'h000, 1'b0, 10'h000, 10'h000, 10'h000, 3'b011},
    {10'h000, 1'b0, 10'h000, 10'h000, 10'h000, 3'b011},
    {10'h300, 1'b0, 10'h000, 10'h000, 10'h000, 3'b100},
    {10'h050, 1'b0, 10'h000, 10'h000, 10'h000, 3'b100},
    {10'h060, 1'b0, 10'h000, 10'h000, 10'h000, 3'b100},
    {10'h3FF, 1'b0, 10'h000, 10'h000, 10'h000, 3'b100},
    {10'h000, 1'b0, 10'h000, 10'h000, 10'h000, 3'b100},
    {10'h000, 1'b0, 10'h000, 10'h000, 10'h000, 3'b100},
    {10'h200, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h010, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h040, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h210, 1'b0, 10'h000, 10'h000, 10'h000, 3'b000},
    {10'h07F, 1'b1, 10'h000, 10'h210, 10'h010, 3'b000},
    {10'h200, 1'b1, 10'h03F, 10'h210, 10'h010, 3'b000}
  };

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      failures++;
      $display("FAIL watchdog: got %0d cycles exp at most 5000", cycles);
      report();
    end
  end

  // Drive one word at a negedge, then check the outputs at the following negedge.
  task automatic step(input logic [9:0] w, input logic he, input logic hi,
                      input logic ev, input logic [9:0] ey, input logic [9:0] ecb,
                      input logic [9:0] ecr, input logic chkf, input logic [2:0] efvh,
                      input string rq);
    din = w;
    hs_ext_n = he;
    hs_int_n = hi;
    @(negedge clk);
    checks++;
    if (pix_vld !== ev) begin
      failures++;
      $display("FAIL %s: pix_vld got %0b exp %0b (word %h)", rq, pix_vld, ev, w);
    end else if (ev && (y_out !== ey || cb_out !== ecb || cr_out !== ecr)) begin
      failures++;
      $display("FAIL %s: y/cb/cr got %h/%h/%h exp %h/%h/%h", rq, y_out, cb_out, cr_out, ey, ecb, ecr);
    end
    if (chkf) begin
      checks++;
      if ({f_flag, v_flag, h_flag} !== efvh) begin
        failures++;
        $display("FAIL R4: fvh got %b exp %b", {f_flag, v_flag, h_flag}, efvh);
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    din = '0;
    hs_ext_n = 1'b1;
    hs_int_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (pix_vld !== 1'b0 || y_out !== 0 || cb_out !== 0 || cr_out !== 0 ||
        {f_flag, v_flag, h_flag} !== 3'b000) begin
      failures++;
      $display("FAIL R11: vld/y/cb/cr/fvh got %b/%h/%h/%h/%b exp 0/000/000/000/000",
               pix_vld, y_out, cb_out, cr_out, {f_flag, v_flag, h_flag});
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    sync_src = 2'd0;
    luma_ofs_en = 1'b1;
    chroma_inv_en = 1'b1;
    do_reset();

    // Embedded-code mode: R1 R2 R3 R4 R5 R6 R9 R10 through the table
    for (int i = 0; i < NT; i++) begin
      step(TBL[i][43:34], 1'b1, 1'b1, TBL[i][33], TBL[i][32:23], TBL[i][22:13],
           TBL[i][12:3], 1'b1, TBL[i][2:0], "R3/R5/R6 table");
    end

    // External sync mode, formatting off (R7, R9 and R10 pass-through)
    sync_src = 2'd1;
    luma_ofs_en = 1'b0;
    chroma_inv_en = 1'b0;
    do_reset();
    step(10'h155, 1'b1, 1'b1, 1'b0, 0, 0, 0, 1'b0, 3'b0, "R7 before edge");
    step(10'h3FF, 1'b1, 1'b1, 1'b0, 0, 0, 0, 1'b0, 3'b0, "R7 before edge");
    step(10'h011, 1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, 3'b0, "R7 edge Cb");
    step(10'h022, 1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, 3'b0, "R7");
    step(10'h033, 1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, 3'b0, "R7");
    step(10'h244, 1'b1, 1'b1, 1'b1, 10'h022, 10'h011, 10'h033, 1'b0, 3'b0, "R7 R9 R1 first pixel");
    step(10'h255, 1'b1, 1'b1, 1'b1, 10'h244, 10'h011, 10'h033, 1'b0, 3'b0, "R10 R1 second pixel");
    step(10'h066, 1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, 3'b0, "R7 realign");
    step(10'h077, 1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, 3'b0, "R7");
    step(10'h088, 1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, 3'b0, "R7");
    step(10'h099, 1'b0, 1'b1, 1'b1, 10'h077, 10'h066, 10'h088, 1'b0, 3'b0, "R7 partial dropped");
    step(10'h0AA, 1'b0, 1'b1, 1'b1, 10'h099, 10'h066, 10'h088, 1'b0, 3'b0, "R2 second pixel");
    step(10'h0BB, 1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, 3'b0, "R2 pair ends");

    // Internal sync mode (R8)
    sync_src = 2'd2;
    do_reset();
    step(10'h1FF, 1'b1, 1'b1, 1'b0, 0, 0, 0, 1'b0, 3'b0, "R8 before edge");
    step(10'h2AA, 1'b1, 1'b0, 1'b0, 0, 0, 0, 1'b0, 3'b0, "R8 edge word dropped");
    step(10'h101, 1'b1, 1'b0, 1'b0, 0, 0, 0, 1'b0, 3'b0, "R8 Cb");
    step(10'h102, 1'b1, 1'b0, 1'b0, 0, 0, 0, 1'b0, 3'b0, "R8");
    step(10'h103, 1'b1, 1'b0, 1'b0, 0, 0, 0, 1'b0, 3'b0, "R8");
    step(10'h104, 1'b1, 1'b0, 1'b1, 10'h102, 10'h101, 10'h103, 1'b0, 3'b0, "R8 first pixel");
    step(10'h105, 1'b1, 1'b0, 1'b1, 10'h104, 10'h101, 10'h103, 1'b0, 3'b0, "R8 second pixel");

    report();
  end
endmodule